// File: doc/BRIEF.md
# Synchronous Burst Address Controller

This block holds the word address and the cycle type of a synchronous burst SRAM. On each rising clock edge it decides whether to load a new external address, advance the burst, hold it, or deselect the device. A cycle can start from either of two active-low address strobes. The processor strobe always starts a read, and the master chip enable blocks it. The controller strobe ignores the master chip enable, and the write-enable level sampled with it decides between read and write.

After a start, the burst-advance input steps the two low address bits through a four-word group. The group is walked in interleaved or linear order, as chosen by the order-select level sampled at the start. The upper address bits stay the same for the whole burst. The outputs drive the memory array and the data path. Byte-lane decoding and data registers are in other blocks.

Top module: `burst_addr_ctrl`

## Requirements
- R1: When `cpu_strb_n` is sampled low and all three chip enables are active (`ce_main_n`=0, `ce_hi`=1, `ce_lo_n`=0), the next `word_addr` equals `ext_addr` and `cyc_kind` becomes read (2'b01). This holds whatever the levels of `wr_n` and `ctl_strb_n`.
- R2: On an edge that starts a cycle, `adv_n` is ignored. The loaded address is the external address itself (beat 0), even with `adv_n` low.
- R3: When both strobes are sampled high, `adv_n` is sampled low and a cycle is active, the burst moves to the next beat. `word_addr[AW-1:2]` never changes while both strobes are high. After four advances the low bits return to the start value.
- R4: With `order_ilv`=1 sampled at the start, the low two bits at beat k equal (start bits XOR k).
- R5: With `order_ilv`=0 sampled at the start, the low two bits at beat k equal (start bits + k) modulo 4.
- R6: When `cpu_strb_n` is high, `ctl_strb_n` is low and `ce_hi`=1, `ce_lo_n`=0, the address is loaded. `cyc_kind` becomes write (2'b10) if `wr_n` is 0 and read (2'b01) if `wr_n` is 1.
- R7: `ce_main_n` high blocks a processor-strobe start but has no effect on a controller-strobe start.
- R8: With both strobes high and `adv_n` high, `word_addr` and `cyc_kind` keep their values (burst suspended).
- R9: A strobe that does not make a valid start sets `cyc_kind` to deselected (2'b00) and leaves `word_addr` unchanged. While deselected, `adv_n` low does not move the address.
- R10: While `rst_n` is low, `word_addr` is 0 and `cyc_kind` is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_addr | input | AW | External word address |
| cpu_strb_n | input | 1 | Processor address strobe, active low |
| ctl_strb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_main_n | input | 1 | Master chip enable, active low |
| ce_hi | input | 1 | Secondary chip enable, active high |
| ce_lo_n | input | 1 | Secondary chip enable, active low |
| wr_n | input | 1 | Write enable, active low, used on controller starts |
| order_ilv | input | 1 | Burst order select: 1 interleaved, 0 linear |
| word_addr | output | AW | Current internal word address |
| cyc_kind | output | 2 | 00 deselected, 01 read, 10 write |

## Verification
The assertions assume that every input is a known 0 or 1 at each sampling edge. They also assume that `rst_n` is held low for at least one edge before normal operation. The bench changes inputs only one nanosecond after a rising edge, so each edge sees a settled, fully defined input set. During reset it keeps the strobes at their inactive level.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
    localparam int LOW_W = 2;

    typedef enum logic [1:0] {
        KIND_IDLE  = 2'b00,
        KIND_READ  = 2'b01,
        KIND_WRITE = 2'b10
    } cyc_kind_e;
endpackage

// File: rtl/burst_start_decode.sv
module burst_start_decode (
    input  logic cpu_strb_n,
    input  logic ctl_strb_n,
    input  logic ce_main_n,
    input  logic ce_hi,
    input  logic ce_lo_n,
    input  logic wr_n,
    output logic start_vld,
    output logic desel,
    output logic start_wr,
    output logic strobes_idle
);
    logic cpu_sel;
    logic ctl_sel;
    logic sub_ok;

    always_comb begin
        cpu_sel      = !cpu_strb_n;
        ctl_sel      = cpu_strb_n && !ctl_strb_n;
        sub_ok       = ce_hi && !ce_lo_n;
        // processor start needs the master enable; controller start does not
        start_vld    = cpu_sel ? (sub_ok && !ce_main_n) : (ctl_sel && sub_ok);
        desel        = (cpu_sel || ctl_sel) && !start_vld;
        start_wr     = ctl_sel && !wr_n;
        strobes_idle = cpu_strb_n && ctl_strb_n;
    end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import burst_addr_pkg::*;
(
    input  logic [LOW_W-1:0] base,
    input  logic [LOW_W-1:0] beat,
    input  logic             ilv,
    output logic [LOW_W-1:0] low
);
    always_comb begin
        if (ilv) low = base ^ beat;
        else     low = base + beat;
    end
endmodule

// File: rtl/burst_addr_ctrl.sv
module burst_addr_ctrl
    import burst_addr_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ext_addr,
    input  logic          cpu_strb_n,
    input  logic          ctl_strb_n,
    input  logic          adv_n,
    input  logic          ce_main_n,
    input  logic          ce_hi,
    input  logic          ce_lo_n,
    input  logic          wr_n,
    input  logic          order_ilv,
    output logic [AW-1:0] word_addr,
    output logic [1:0]    cyc_kind
);
    localparam int HI_W = AW - LOW_W;

    typedef struct packed {
        logic [AW-1:0]    addr;
        logic [LOW_W-1:0] base;
        logic [LOW_W-1:0] beat;
        logic             ilv;
        cyc_kind_e        kind;
    } st_t;

    st_t st_d, st_q;

    logic             start_vld, desel, start_wr, strobes_idle;
    logic [LOW_W-1:0] beat_nx;
    logic [LOW_W-1:0] low_nx;

    burst_start_decode i_dec (
        .cpu_strb_n  (cpu_strb_n),
        .ctl_strb_n  (ctl_strb_n),
        .ce_main_n   (ce_main_n),
        .ce_hi       (ce_hi),
        .ce_lo_n     (ce_lo_n),
        .wr_n        (wr_n),
        .start_vld   (start_vld),
        .desel       (desel),
        .start_wr    (start_wr),
        .strobes_idle(strobes_idle)
    );

    assign beat_nx = st_q.beat + 1'b1;

    burst_seq i_seq (
        .base(st_q.base),
        .beat(beat_nx),
        .ilv (st_q.ilv),
        .low (low_nx)
    );

    always_comb begin
        st_d = st_q;
        if (start_vld) begin
            st_d.addr = ext_addr;
            st_d.base = ext_addr[LOW_W-1:0];
            st_d.beat = '0;
            st_d.ilv  = order_ilv;
            st_d.kind = start_wr ? KIND_WRITE : KIND_READ;
        end else if (desel) begin
            st_d.kind = KIND_IDLE;
        end else if (strobes_idle && !adv_n && st_q.kind != KIND_IDLE) begin
            st_d.beat             = beat_nx;
            st_d.addr[LOW_W-1:0]  = low_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.addr <= '0;
            st_q.base <= '0;
            st_q.beat <= '0;
            st_q.ilv  <= 1'b0;
            st_q.kind <= KIND_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_addr = st_q.addr;
    assign cyc_kind  = st_q.kind;

    // R1
    cpu_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_strb_n && !ce_main_n && ce_hi && !ce_lo_n)
        |=> (word_addr == $past(ext_addr) && cyc_kind == 2'b01));

    // R6
    ctl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_strb_n && !ctl_strb_n && ce_hi && !ce_lo_n)
        |=> (word_addr == $past(ext_addr)
             && cyc_kind == ($past(wr_n) ? 2'b01 : 2'b10)));

    // R7
    main_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_strb_n && ce_main_n) |=> (cyc_kind == 2'b00));

    // R8
    suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_strb_n && ctl_strb_n && adv_n)
        |=> ($stable(word_addr) && $stable(cyc_kind)));

    // R3
    upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_strb_n && ctl_strb_n)
        |=> (word_addr[AW-1:LOW_W] == $past(word_addr[AW-1:LOW_W])));

    // R9
    desel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!cpu_strb_n || !ctl_strb_n) && !(ce_hi && !ce_lo_n))
        |=> (cyc_kind == 2'b00 && $stable(word_addr)));

    // R9
    idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_kind == 2'b00 && cpu_strb_n && ctl_strb_n)
        |=> (cyc_kind == 2'b00 && $stable(word_addr)));
endmodule

// File: tb/test_burst_addr_ctrl.sv
module test_burst_addr_ctrl;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] ext_addr;
    logic          cpu_strb_n, ctl_strb_n, adv_n;
    logic          ce_main_n, ce_hi, ce_lo_n, wr_n, order_ilv;
    logic [AW-1:0] word_addr;
    logic [1:0]    cyc_kind;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    burst_addr_ctrl #(.AW(AW)) i_burst_addr_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr),
        .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n), .adv_n(adv_n),
        .ce_main_n(ce_main_n), .ce_hi(ce_hi), .ce_lo_n(ce_lo_n),
        .wr_n(wr_n), .order_ilv(order_ilv),
        .word_addr(word_addr), .cyc_kind(cyc_kind)
    );

    task automatic check(input string req, input logic [AW-1:0] ea, input logic [1:0] ek);
        n_chk++;
        if (word_addr !== ea || cyc_kind !== ek) begin
            n_bad++;
            $display("FAIL %s: addr=%h kind=%b expected addr=%h kind=%b",
                     req, word_addr, cyc_kind, ea, ek);
        end
    endtask

    task automatic idle_in();
        cpu_strb_n = 1'b1; ctl_strb_n = 1'b1; adv_n = 1'b1;
        ce_main_n = 1'b0; ce_hi = 1'b1; ce_lo_n = 1'b0;
        wr_n = 1'b1; order_ilv = 1'b0; ext_addr = 20'h0F0F0;
    endtask

    task automatic clk1();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        idle_in();
        rst_n = 1'b0;
        clk1(); clk1();
        check("R10 reset", '0, 2'b00);
        rst_n = 1'b1;
    endtask

    task automatic run_burst(input string req, input logic [AW-1:0] st, input bit ilv, input logic [1:0] kind);
        for (int k = 1; k <= 4; k++) begin
            logic [1:0] lo;
            lo = ilv ? (st[1:0] ^ 2'(k)) : (st[1:0] + 2'(k));
            idle_in(); adv_n = 1'b0; ext_addr = 20'h55555;
            clk1();
            check(req, {st[AW-1:2], lo}, kind);
        end
    endtask

    task automatic t_cpu_ilv();
        idle_in();
        ext_addr = 20'hABCD6; cpu_strb_n = 1'b0; ctl_strb_n = 1'b0;
        wr_n = 1'b0; adv_n = 1'b0; order_ilv = 1'b1;
        clk1();
        check("R1 R2 cpu start", 20'hABCD6, 2'b01);
        run_burst("R4 R3 interleaved", 20'hABCD6, 1'b1, 2'b01);
    endtask

    task automatic t_cpu_lin();
        idle_in();
        ext_addr = 20'h13571; cpu_strb_n = 1'b0; order_ilv = 1'b0;
        clk1();
        check("R1 cpu start linear", 20'h13571, 2'b01);
        run_burst("R5 R3 linear", 20'h13571, 1'b0, 2'b01);
    endtask

    task automatic t_ctl();
        idle_in();
        ext_addr = 20'h2468B; ctl_strb_n = 1'b0; ce_main_n = 1'b1;
        wr_n = 1'b0; order_ilv = 1'b1;
        clk1();
        check("R6 R7 ctl write, master off", 20'h2468B, 2'b10);
        idle_in(); adv_n = 1'b0;
        clk1();
        check("R4 ctl write advance", 20'h2468A, 2'b10);
        idle_in();
        ext_addr = 20'h9ABC3; ctl_strb_n = 1'b0; wr_n = 1'b1;
        clk1();
        check("R6 ctl read", 20'h9ABC3, 2'b01);
    endtask

    task automatic t_master_block();
        idle_in();
        ext_addr = 20'h11110; cpu_strb_n = 1'b0; ce_main_n = 1'b1;
        clk1();
        check("R7 R9 master blocks cpu start", 20'h9ABC3, 2'b00);
    endtask

    task automatic t_suspend();
        idle_in();
        ext_addr = 20'h70002; cpu_strb_n = 1'b0; order_ilv = 1'b0;
        clk1();
        check("R1 start before suspend", 20'h70002, 2'b01);
        for (int i = 0; i < 3; i++) begin
            idle_in();
            clk1();
            check("R8 suspend hold", 20'h70002, 2'b01);
        end
        idle_in(); adv_n = 1'b0;
        clk1();
        check("R5 resume after suspend", 20'h70003, 2'b01);
    endtask

    task automatic t_desel();
        idle_in();
        ext_addr = 20'h33331; ctl_strb_n = 1'b0; ce_hi = 1'b0;
        clk1();
        check("R9 deselect by secondary enable", 20'h70003, 2'b00);
        idle_in(); adv_n = 1'b0;
        clk1();
        check("R9 advance ignored while deselected", 20'h70003, 2'b00);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        t_reset();
        t_cpu_ilv();
        t_cpu_lin();
        t_ctl();
        t_master_block();
        t_suspend();
        t_desel();
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
        end
    end
endmodule